// File: doc/BRIEF.md
# Predicated Element Issue Sequencer

This block turns one vectorised scalar operation into a stream of per-element scalar micro-ops for the issue stage of a core. A command carries the following:

- a vector length;
- a predicate bitmask, one bit per element;
- a zeroing mode;
- for the destination and for each of the two sources, a base register number and a flag that marks the operand as a vector or a scalar.

The block only sequences register numbers and element indices. The ALU, the register file, element-width subdivision and the decoding of configuration registers sit outside it.

Elements that are masked off are squeezed out, so each output group carries up to four live elements. The number of groups therefore follows the count of selected elements, not the vector length. In zeroing mode a masked-off element is still issued, marked as a write of zero. A vector operand steps its register number with the element index. A scalar operand keeps its base register. When all three operands are scalar, the command degenerates into one ordinary scalar op.

Both data sides use valid/ready. A command transfers on a rising edge where `cmd_valid` and `cmd_ready` are both high, and `cmd_ready` is high only while the sequencer is idle. A micro-op group transfers on a rising edge where `uop_valid` and `uop_ready` are both high. While `uop_ready` is low, the presented group stays unchanged. `seq_done` is a plain one-cycle pulse.

Top module: `pred_issue_seq`

## Requirements
- R1: `cmd_ready` is 1 whenever no command is in progress and 0 from the cycle after a command that produces micro-ops is accepted until its final group has transferred.
- R2: In non-zeroing mode, exactly the elements i with i < VL and predicate bit i set are issued, in ascending index order; predicate bits at positions VL and above have no effect.
- R3: Each group fills lanes from lane 0 upward with no gaps, carries up to 4 elements, and a command with K issued elements needs ceil(K/4) groups (8 elements with 6 bits set gives 4 then 2).
- R4: For an operand flagged as vector, the lane register number is (base + element index) mod 32; for a scalar operand it is the base.
- R5: In zeroing mode every element below VL is issued, and its lane zero flag is 1 exactly when its predicate bit is 0; in non-zeroing mode every zero flag is 0.
- R6: When rd, rs1 and rs2 are all scalar, exactly one group is issued with only lane 0 enabled, index 0, the three base registers and zero flag 0, whatever VL and the predicate are.
- R7: While `uop_valid` is 1 and `uop_ready` is 0, `uop_valid` and every group field hold their values into the next cycle.
- R8: `seq_done` is 1 for exactly one cycle, the cycle after the final group transfers; a command with VL of 0, or with an empty selection in non-zeroing mode, issues nothing and raises `seq_done` in the cycle after it is accepted.
- R9: A VL above 32 is handled as 32.
- R10: During and straight after reset, `cmd_ready` is 1, `uop_valid` is 0 and `seq_done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command may transfer |
| cmd_vlen | input | 6 | Vector length, 0 to 63 (above 32 clamps) |
| cmd_pred | input | 32 | Predicate bitmask, bit i for element i |
| cmd_zero | input | 1 | Zeroing mode |
| cmd_rd | input | 5 | Destination base register |
| cmd_rd_vec | input | 1 | Destination is a vector |
| cmd_rs1 | input | 5 | First source base register |
| cmd_rs1_vec | input | 1 | First source is a vector |
| cmd_rs2 | input | 5 | Second source base register |
| cmd_rs2_vec | input | 1 | Second source is a vector |
| uop_valid | output | 1 | Group offered |
| uop_ready | input | 1 | Consumer takes the group |
| uop_lane_en | output | 4 | Lane k carries an element |
| uop_idx | output | 20 | Element index, 5 bits per lane, lane k at bits 5k+4:5k |
| uop_rd | output | 20 | Destination register, 5 bits per lane |
| uop_rs1 | output | 20 | First source register, 5 bits per lane |
| uop_rs2 | output | 20 | Second source register, 5 bits per lane |
| uop_zero | output | 4 | Lane k writes zero |
| seq_done | output | 1 | One-cycle completion pulse |

## Verification
A command accepted on edge T gives `uop_valid` and its first group from T+1. Each group taken on an edge is replaced one cycle later. `seq_done` and the restored `cmd_ready` appear one cycle after the final group transfers, or one cycle after acceptance for a command that issues nothing. The reference model updates its queue of expected elements on every rising edge from the same inputs the design sees. All outputs are compared against that model at every falling edge, so each result is sampled one register stage after its cause. Back-pressure is applied from a pseudo-random pattern, so held groups are compared on the cycles in which they must not move.

// File: rtl/pis_pkg.sv
package pis_pkg;
  // Register file index width of the scalar core.
  localparam int unsigned REG_W = 5;

  typedef struct packed {
    logic [REG_W-1:0] base;
    logic             is_vec;
  } opnd_t;
endpackage

// File: rtl/pis_lane_pick.sv
// Picks the lowest LANES set bits of a pending mask, one per lane, in order.
module pis_lane_pick #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned LANES = 4,
  localparam int unsigned IDXW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0]       pend,
  output logic [LANES-1:0]      lane_vld,
  output logic [LANES*IDXW-1:0] lane_idx,
  output logic [XLEN-1:0]       taken
);
  logic [XLEN-1:0] rem;
  logic [XLEN-1:0] oh;
  localparam logic [XLEN-1:0] ONE = {{(XLEN-1){1'b0}}, 1'b1};

  always_comb begin
    rem      = pend;
    oh       = '0;
    lane_vld = '0;
    lane_idx = '0;
    for (int k = 0; k < LANES; k++) begin
      oh          = rem & (~rem + ONE);
      lane_vld[k] = |rem;
      for (int b = 0; b < XLEN; b++) begin
        if (oh[b]) lane_idx[k*IDXW +: IDXW] = IDXW'(b);
      end
      rem = rem & ~oh;
    end
    taken = pend & ~rem;
  end

  // Checks on the picked lanes.
  int nv;
  always_comb begin
    nv = 0;
    for (int k = 0; k < LANES; k++) nv = nv + int'(lane_vld[k]);
    p_count_r3: assert ($countones(taken) == nv)
      else $error("taken bits differ from filled lanes");
    for (int k = 1; k < LANES; k++) begin
      p_packed_r3: assert (!lane_vld[k] || lane_vld[k-1])
        else $error("lane gap");
      p_order_r2: assert (!lane_vld[k] ||
                          (lane_idx[k*IDXW +: IDXW] > lane_idx[(k-1)*IDXW +: IDXW]))
        else $error("element order");
    end
  end
endmodule

// File: rtl/pis_reg_map.sv
// Maps per-lane element indices to register numbers for one operand.
module pis_reg_map
  import pis_pkg::*;
#(
  parameter int unsigned LANES = 4,
  parameter int unsigned IDXW  = 5
) (
  input  opnd_t                  opnd,
  input  logic [LANES*IDXW-1:0]  lane_idx,
  output logic [LANES*REG_W-1:0] lane_reg
);
  localparam int unsigned SUMW = IDXW + REG_W;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [IDXW-1:0] off;
    logic [SUMW-1:0] sum;
    assign off = opnd.is_vec ? lane_idx[k*IDXW +: IDXW] : '0;
    assign sum = {{IDXW{1'b0}}, opnd.base} + {{REG_W{1'b0}}, off};
    assign lane_reg[k*REG_W +: REG_W] = sum[REG_W-1:0];
  end
endmodule

// File: rtl/pis_ctrl.sv
// Command capture, pending-element mask and completion control.
module pis_ctrl #(
  parameter int unsigned XLEN = 32,
  localparam int unsigned VLW = $clog2(XLEN+1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [VLW-1:0]  cmd_vlen,
  input  logic [XLEN-1:0] cmd_pred,
  input  logic            cmd_zero,
  input  logic            cmd_scalar,
  input  logic [XLEN-1:0] taken,
  input  logic            uop_ready,
  output logic            uop_valid,
  output logic [XLEN-1:0] pend_q,
  output logic [XLEN-1:0] pred_q,
  output logic            zmode_q,
  output logic            scal_q,
  output logic            done_q
);
  localparam logic [VLW-1:0] VL_MAX = VLW'(XLEN);
  localparam logic [XLEN-1:0] FIRST = {{(XLEN-1){1'b0}}, 1'b1};

  logic            busy_q;
  logic [VLW-1:0]  vl_c;
  logic [XLEN-1:0] vmask;
  logic [XLEN-1:0] start_mask;
  logic [XLEN-1:0] pend_left;
  logic            cmd_fire;
  logic            uop_fire;

  assign cmd_ready = !busy_q;
  assign uop_valid = busy_q;
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign uop_fire  = uop_valid && uop_ready;
  assign pend_left = pend_q & ~taken;

  always_comb begin
    vl_c = (cmd_vlen > VL_MAX) ? VL_MAX : cmd_vlen;
    for (int i = 0; i < XLEN; i++) vmask[i] = (i < int'(vl_c));
    if (cmd_scalar)    start_mask = FIRST;
    else if (cmd_zero) start_mask = vmask;
    else               start_mask = vmask & cmd_pred;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      pend_q  <= '0;
      pred_q  <= '0;
      zmode_q <= 1'b0;
      scal_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (cmd_fire) begin
        pred_q  <= cmd_pred;
        zmode_q <= cmd_zero;
        scal_q  <= cmd_scalar;
        pend_q  <= start_mask;
        if (start_mask == '0) done_q <= 1'b1;
        else                  busy_q <= 1'b1;
      end else if (uop_fire) begin
        pend_q <= pend_left;
        if (pend_left == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && !uop_ready) |=> (uop_valid && $stable(pend_q)));
  p_work_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (pend_q != '0));
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> cmd_ready);
  p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(cmd_valid));
endmodule

// File: rtl/pred_issue_seq.sv
module pred_issue_seq
  import pis_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned LANES = 4,
  localparam int unsigned IDXW = $clog2(XLEN),
  localparam int unsigned VLW  = $clog2(XLEN+1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  output logic                   cmd_ready,
  input  logic [VLW-1:0]         cmd_vlen,
  input  logic [XLEN-1:0]        cmd_pred,
  input  logic                   cmd_zero,
  input  logic [REG_W-1:0]       cmd_rd,
  input  logic                   cmd_rd_vec,
  input  logic [REG_W-1:0]       cmd_rs1,
  input  logic                   cmd_rs1_vec,
  input  logic [REG_W-1:0]       cmd_rs2,
  input  logic                   cmd_rs2_vec,
  output logic                   uop_valid,
  input  logic                   uop_ready,
  output logic [LANES-1:0]       uop_lane_en,
  output logic [LANES*IDXW-1:0]  uop_idx,
  output logic [LANES*REG_W-1:0] uop_rd,
  output logic [LANES*REG_W-1:0] uop_rs1,
  output logic [LANES*REG_W-1:0] uop_rs2,
  output logic [LANES-1:0]       uop_zero,
  output logic                   seq_done
);
  logic            cmd_scalar;
  logic [XLEN-1:0] pend_q;
  logic [XLEN-1:0] pred_q;
  logic [XLEN-1:0] taken;
  logic            zmode_q;
  logic            scal_q;
  logic [LANES-1:0] lane_vld;
  opnd_t           rd_q, rs1_q, rs2_q;

  assign cmd_scalar = !cmd_rd_vec && !cmd_rs1_vec && !cmd_rs2_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q  <= '0;
      rs1_q <= '0;
      rs2_q <= '0;
    end else if (cmd_valid && cmd_ready) begin
      rd_q  <= '{base: cmd_rd,  is_vec: cmd_rd_vec};
      rs1_q <= '{base: cmd_rs1, is_vec: cmd_rs1_vec};
      rs2_q <= '{base: cmd_rs2, is_vec: cmd_rs2_vec};
    end
  end

  pis_ctrl #(.XLEN(XLEN)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_vlen  (cmd_vlen),
    .cmd_pred  (cmd_pred),
    .cmd_zero  (cmd_zero),
    .cmd_scalar(cmd_scalar),
    .taken     (taken),
    .uop_ready (uop_ready),
    .uop_valid (uop_valid),
    .pend_q    (pend_q),
    .pred_q    (pred_q),
    .zmode_q   (zmode_q),
    .scal_q    (scal_q),
    .done_q    (seq_done)
  );

  pis_lane_pick #(.XLEN(XLEN), .LANES(LANES)) u_pick (
    .pend    (pend_q),
    .lane_vld(lane_vld),
    .lane_idx(uop_idx),
    .taken   (taken)
  );

  pis_reg_map #(.LANES(LANES), .IDXW(IDXW)) u_map_rd (
    .opnd(rd_q), .lane_idx(uop_idx), .lane_reg(uop_rd));
  pis_reg_map #(.LANES(LANES), .IDXW(IDXW)) u_map_rs1 (
    .opnd(rs1_q), .lane_idx(uop_idx), .lane_reg(uop_rs1));
  pis_reg_map #(.LANES(LANES), .IDXW(IDXW)) u_map_rs2 (
    .opnd(rs2_q), .lane_idx(uop_idx), .lane_reg(uop_rs2));

  for (genvar k = 0; k < LANES; k++) begin : g_out
    assign uop_lane_en[k] = lane_vld[k] && uop_valid;
    assign uop_zero[k]    = uop_lane_en[k] && zmode_q && !scal_q &&
                            !pred_q[uop_idx[k*IDXW +: IDXW]];
  end

  // Scalar pass-through issues one lane only (R6).
  p_scalar_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && scal_q) |-> (uop_lane_en == LANES'(1) && uop_zero == '0));
  p_zero_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && !zmode_q) |-> (uop_zero == '0));
endmodule

// File: tb/test_pred_issue_seq.sv
module test_pred_issue_seq;
  localparam int CLK_PERIOD = 10;
  localparam int LN = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [5:0]  cmd_vlen = '0;
  logic [31:0] cmd_pred = '0;
  logic        cmd_zero = 1'b0;
  logic [4:0]  cmd_rd = '0, cmd_rs1 = '0, cmd_rs2 = '0;
  logic        cmd_rd_vec = 1'b0, cmd_rs1_vec = 1'b0, cmd_rs2_vec = 1'b0;
  logic        uop_valid;
  logic        uop_ready;
  logic [3:0]  uop_lane_en, uop_zero;
  logic [19:0] uop_idx, uop_rd, uop_rs1, uop_rs2;
  logic        seq_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  pred_issue_seq i_pred_issue_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_vlen(cmd_vlen), .cmd_pred(cmd_pred), .cmd_zero(cmd_zero),
    .cmd_rd(cmd_rd), .cmd_rd_vec(cmd_rd_vec), .cmd_rs1(cmd_rs1),
    .cmd_rs1_vec(cmd_rs1_vec), .cmd_rs2(cmd_rs2), .cmd_rs2_vec(cmd_rs2_vec),
    .uop_valid(uop_valid), .uop_ready(uop_ready), .uop_lane_en(uop_lane_en),
    .uop_idx(uop_idx), .uop_rd(uop_rd), .uop_rs1(uop_rs1), .uop_rs2(uop_rs2),
    .uop_zero(uop_zero), .seq_done(seq_done)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  string scen = "R10";
  bit    finished = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s [%s] %s: actual %0d expected %0d", tag, scen, what, act, exp);
    end
  endtask

  // Back-pressure source.
  bit        bp_mode = 0;
  logic [7:0] lfsr = 8'hA5;
  always @(negedge clk) begin
    lfsr      = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    uop_ready = bp_mode ? lfsr[0] : 1'b1;
  end

  // Behavioural reference model: queue of expected elements.
  int q_idx[$];
  int q_zero[$];
  bit ref_busy = 0;
  bit ref_done = 0;
  int l_rd, l_rs1, l_rs2;
  bit l_rdv, l_r1v, l_r2v;

  always @(posedge clk) begin
    if (!rst_n) begin
      ref_busy = 0; ref_done = 0; q_idx.delete(); q_zero.delete();
    end else begin
      ref_done = 0;
      if (ref_busy) begin
        if (uop_ready) begin
          for (int k = 0; k < LN; k++)
            if (q_idx.size() > 0) begin
              void'(q_idx.pop_front()); void'(q_zero.pop_front());
            end
          if (q_idx.size() == 0) begin ref_busy = 0; ref_done = 1; end
        end
      end else if (cmd_valid) begin
        int vl;
        l_rd = cmd_rd; l_rs1 = cmd_rs1; l_rs2 = cmd_rs2;
        l_rdv = cmd_rd_vec; l_r1v = cmd_rs1_vec; l_r2v = cmd_rs2_vec;
        vl = (cmd_vlen > 32) ? 32 : int'(cmd_vlen);
        if (!l_rdv && !l_r1v && !l_r2v) begin
          q_idx.push_back(0); q_zero.push_back(0);
        end else begin
          for (int i = 0; i < vl; i++) begin
            if (cmd_pred[i]) begin q_idx.push_back(i); q_zero.push_back(0); end
            else if (cmd_zero) begin q_idx.push_back(i); q_zero.push_back(1); end
          end
        end
        if (q_idx.size() == 0) ref_done = 1;
        else ref_busy = 1;
      end
    end
  end

  // Compare against the model away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R1", "cmd_ready", int'(cmd_ready), int'(!ref_busy));
      chk("R3", "uop_valid", int'(uop_valid), int'(ref_busy));
      chk("R8", "seq_done", int'(seq_done), int'(ref_done));
      if (ref_busy) begin
        for (int k = 0; k < LN; k++) begin
          bit en;
          en = (k < q_idx.size());
          chk("R3", $sformatf("lane%0d_en", k), int'(uop_lane_en[k]), int'(en));
          if (en) begin
            int e;
            e = q_idx[k];
            chk("R2", $sformatf("lane%0d_idx", k), int'(uop_idx[k*5 +: 5]), e);
            chk("R4", $sformatf("lane%0d_rd", k), int'(uop_rd[k*5 +: 5]),
                l_rdv ? (l_rd + e) % 32 : l_rd);
            chk("R4", $sformatf("lane%0d_rs1", k), int'(uop_rs1[k*5 +: 5]),
                l_r1v ? (l_rs1 + e) % 32 : l_rs1);
            chk("R4", $sformatf("lane%0d_rs2", k), int'(uop_rs2[k*5 +: 5]),
                l_r2v ? (l_rs2 + e) % 32 : l_rs2);
            chk("R5", $sformatf("lane%0d_zero", k), int'(uop_zero[k]), q_zero[k]);
          end
        end
      end
    end
  end

  task automatic send(input int vl, input logic [31:0] pr, input bit z,
                      input int rd, input bit rdv, input int r1, input bit r1v,
                      input int r2, input bit r2v);
    @(negedge clk);
    cmd_vlen = 6'(vl); cmd_pred = pr; cmd_zero = z;
    cmd_rd = 5'(rd); cmd_rd_vec = rdv; cmd_rs1 = 5'(r1); cmd_rs1_vec = r1v;
    cmd_rs2 = 5'(r2); cmd_rs2_vec = r2v; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (ref_busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    chk("R10", "cmd_ready", int'(cmd_ready), 1);
    chk("R10", "uop_valid", int'(uop_valid), 0);
    chk("R10", "seq_done", int'(seq_done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "cmd_ready after reset", int'(cmd_ready), 1);

    // R3: 8 elements, 6 selected, groups of 4 then 2
    scen = "R3";
    send(8, 32'h0000_00B7, 0, 2, 1, 10, 1, 20, 1);
    wait_idle();
    // R5: same mask in zeroing mode
    scen = "R5";
    send(8, 32'h0000_00B7, 1, 2, 1, 10, 1, 20, 1);
    wait_idle();
    // R4: mixed scalar/vector operands, wrap past register 31
    scen = "R4";
    send(9, 32'h0000_01FF, 0, 28, 1, 7, 0, 30, 1);
    wait_idle();
    // R2: predicate bits above VL ignored
    scen = "R2";
    send(5, 32'hFFFF_FF12, 0, 0, 1, 0, 1, 0, 0);
    wait_idle();
    // R8: VL zero, and empty mask without zeroing
    scen = "R8";
    send(0, 32'hFFFF_FFFF, 0, 1, 1, 2, 1, 3, 1);
    wait_idle();
    send(12, 32'h0000_0000, 0, 1, 1, 2, 1, 3, 1);
    wait_idle();
    send(3, 32'h0000_0000, 1, 1, 1, 2, 1, 3, 1);
    wait_idle();
    // R6: all-scalar pass-through ignores VL and mask
    scen = "R6";
    send(0, 32'h0, 1, 5, 0, 6, 0, 7, 0);
    wait_idle();
    send(20, 32'hF0F0_F0F0, 0, 9, 0, 9, 0, 9, 0);
    wait_idle();
    // R9: VL above 32 clamps to 32
    scen = "R9";
    send(40, 32'hFFFF_FFFF, 0, 0, 1, 16, 1, 31, 0);
    wait_idle();
    // R7: back-pressure with a sparse mask in zeroing mode
    scen = "R7";
    bp_mode = 1;
    send(32, 32'h8421_1248, 1, 3, 1, 4, 0, 5, 1);
    wait_idle();
    send(17, 32'h0001_A5C3, 0, 11, 1, 12, 1, 13, 1);
    // R1: second command offered while the first is still running
    scen = "R1";
    send(6, 32'h0000_003F, 0, 1, 1, 1, 1, 1, 1);
    wait_idle();
    bp_mode = 0;
    repeat (3) @(negedge clk);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule